// File: doc/BRIEF.md
# PIO Setup and Completion Status Sequencer

This block runs alongside one port of a serial storage host controller. It tracks the single command that the port is currently executing, and at two moments it produces 4-byte status records for the host's received-FIS area. The first moment is the end of each PIO data phase, which produces a PIO setup record. The second is command completion, which produces a device-to-host register record. Along with each record it emits the matching interrupt-status set pulses. At completion it also emits a one-hot mask that clears the finished slot in the command-issue register, and a request to re-examine pending commands when other slots are still issued.

The interrupt flag of the PIO setup record follows a policy. It is set for every data phase after the first. On the first data phase it is set only for a non-packet (ATA) read. For a packet (ATAPI) command, the first data phase carries the command packet, which is already buffered, so the data copy is suppressed for that phase. After reset, when FIS reception is first enabled, the block also emits one unsolicited register record.

Every input event is registered: a record, pulse or mask appears on the outputs exactly one cycle after the clock edge that samples its event, and lasts one cycle.

Top module: `pio_fis_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every write strobe, interrupt pulse, clear mask and recheck output is 0, and `busy_valid_o` is 0.
- R2: `start_i` is accepted only when no command is busy. An accepted start makes `busy_valid_o` 1 and `busy_slot_o` equal to the sampled slot on the next cycle. A start while busy has no effect on `busy_slot_o`.
- R3: A PIO data-phase end with a busy command gives a one-cycle `pio_fis_we_o`. In `pio_fis_o`, bits [7:0] are 0x5F, bit 14 is the interrupt flag, the other bits of [15:8] are 0, bits [23:16] are the device status and bits [31:24] are the device error.
- R4: The interrupt flag is 1 when a previous data phase has already ended for the current command, or when the command is neither ATAPI nor a write. The "previous data phase" flag is cleared on an accepted start and set by every data-phase end.
- R5: `irq_pss_o` pulses together with a PIO record only when that record's interrupt flag is 1.
- R6: `irq_tfes_o` pulses together with a PIO record whenever bit 0 (error) of the device status is 1.
- R7: `copy_en_o` pulses with each PIO record, except the first data phase of an ATAPI command.
- R8: `done_i` with a busy command gives, on the next cycle, all of the following: `ci_clr_o` one-hot at the busy slot; `busy_valid_o` equal to 0; and `d2h_fis_we_o` with `irq_dhrs_o`. In `d2h_fis_o`, bits [7:0] are 0x34, [15:8] are 0x40, [23:16] are the status and [31:24] are the error.
- R9: `recheck_o` pulses with a completion when `issue_i` still has a bit set other than the cleared slot.
- R10: With no busy command, a data-phase end or a completion has no effect on any output. When completion and data-phase end arrive together, only the completion is handled.
- R11: The first cycle after reset in which `rx_on_i` is 1 emits one register record (same format as R8) with `irq_dhrs_o`. It is not emitted again until reset. If a completion is handled in that cycle, the unsolicited record is deferred to the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | New command accepted by the port |
| start_slot_i | input | SLOT_W | Slot of the new command |
| start_atapi_i | input | 1 | New command uses the packet protocol |
| start_write_i | input | 1 | New command moves data host to device |
| issue_i | input | NSLOTS | Current command-issue bits |
| dev_status_i | input | 8 | Device status byte |
| dev_error_i | input | 8 | Device error byte |
| pio_end_i | input | 1 | End of one PIO data phase |
| done_i | input | 1 | Command completion |
| rx_on_i | input | 1 | FIS reception enabled |
| pio_fis_we_o | output | 1 | Write strobe for the PIO setup record |
| pio_fis_o | output | 32 | PIO setup record |
| d2h_fis_we_o | output | 1 | Write strobe for the register record |
| d2h_fis_o | output | 32 | Register record |
| irq_pss_o | output | 1 | PIO setup interrupt-status set pulse |
| irq_tfes_o | output | 1 | Task-file error interrupt-status set pulse |
| irq_dhrs_o | output | 1 | Register record interrupt-status set pulse |
| copy_en_o | output | 1 | Data copy for this phase is performed |
| ci_clr_o | output | NSLOTS | Command-issue clear mask |
| recheck_o | output | 1 | Re-examine pending commands |
| busy_valid_o | output | 1 | A command is in progress |
| busy_slot_o | output | SLOT_W | Slot of the command in progress |

## Verification
The bench builds the block with NSLOTS = 8. This keeps every slot reachable, including the top slot 7, whose one-hot clear is checked. It also lets random `issue_i` patterns produce both completions that leave other slots pending and completions that leave none. Directed sequences cover the flag policy for ATA read, ATA write and ATAPI commands across their first and later phases. They also cover the deferred unsolicited record and the collisions of start, data phase and completion. A random phase then drives all events together against the reference model.

// File: rtl/pio_fis_seq_pkg.sv
package pio_fis_seq_pkg;
    localparam logic [7:0] KIND_PIO_SETUP = 8'h5F;
    localparam logic [7:0] KIND_REG_D2H   = 8'h34;
    localparam int         IRQ_FLAG_BIT   = 6;
    localparam int         STAT_ERR_BIT   = 0;

    typedef struct packed {
        logic [7:0] err;
        logic [7:0] status;
        logic [7:0] flags;
        logic [7:0] kind;
    } fis_hdr_t;
endpackage

// File: rtl/fis_hdr_build.sv
module fis_hdr_build
    import pio_fis_seq_pkg::*;
#(
    parameter logic [7:0] KIND = KIND_PIO_SETUP
) (
    input  logic       irq_flag_i,
    input  logic [7:0] status_i,
    input  logic [7:0] error_i,
    output fis_hdr_t   hdr_o
);
    always_comb begin
        hdr_o                     = '0;
        hdr_o.kind                = KIND;
        hdr_o.flags[IRQ_FLAG_BIT] = irq_flag_i;
        hdr_o.status              = status_i;
        hdr_o.err                 = error_i;
    end
endmodule

// File: rtl/slot_mask_dec.sv
module slot_mask_dec #(
    parameter int NSLOTS = 32,
    localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic              en_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [NSLOTS-1:0] mask_o
);
    for (genvar g = 0; g < NSLOTS; g++) begin : g_bit
        assign mask_o[g] = en_i && (slot_i == SLOT_W'(g));
    end
endmodule

// File: rtl/pio_irq_policy.sv
module pio_irq_policy
    import pio_fis_seq_pkg::*;
(
    input  logic       first_drq_done_i,
    input  logic       atapi_i,
    input  logic       write_i,
    input  logic [7:0] status_i,
    output logic       irq_flag_o,
    output logic       copy_ok_o,
    output logic       err_seen_o
);
    always_comb begin
        irq_flag_o = first_drq_done_i || (!atapi_i && !write_i);
        copy_ok_o  = !(atapi_i && !first_drq_done_i);
        err_seen_o = status_i[STAT_ERR_BIT];
    end
endmodule

// File: rtl/pio_fis_seq.sv
module pio_fis_seq
    import pio_fis_seq_pkg::*;
#(
    parameter int NSLOTS = 32,
    localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SLOT_W-1:0] start_slot_i,
    input  logic              start_atapi_i,
    input  logic              start_write_i,
    input  logic [NSLOTS-1:0] issue_i,
    input  logic [7:0]        dev_status_i,
    input  logic [7:0]        dev_error_i,
    input  logic              pio_end_i,
    input  logic              done_i,
    input  logic              rx_on_i,
    output logic              pio_fis_we_o,
    output logic [31:0]       pio_fis_o,
    output logic              d2h_fis_we_o,
    output logic [31:0]       d2h_fis_o,
    output logic              irq_pss_o,
    output logic              irq_tfes_o,
    output logic              irq_dhrs_o,
    output logic              copy_en_o,
    output logic [NSLOTS-1:0] ci_clr_o,
    output logic              recheck_o,
    output logic              busy_valid_o,
    output logic [SLOT_W-1:0] busy_slot_o
);
    typedef struct packed {
        logic              busy;
        logic [SLOT_W-1:0] slot;
        logic              atapi;
        logic              write;
        logic              first_drq;
        logic              init_sent;
        logic              pio_we;
        fis_hdr_t          pio;
        logic              d2h_we;
        fis_hdr_t          d2h;
        logic              pss;
        logic              tfes;
        logic              dhrs;
        logic              copy;
        logic [NSLOTS-1:0] clr;
        logic              recheck;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic              irq_flag, copy_ok, err_seen;
    logic              done_ok, pio_ok;
    logic [NSLOTS-1:0] slot_mask;
    fis_hdr_t          pio_hdr, d2h_hdr;

    pio_irq_policy u_policy (
        .first_drq_done_i (st_q.first_drq),
        .atapi_i          (st_q.atapi),
        .write_i          (st_q.write),
        .status_i         (dev_status_i),
        .irq_flag_o       (irq_flag),
        .copy_ok_o        (copy_ok),
        .err_seen_o       (err_seen)
    );

    slot_mask_dec #(.NSLOTS(NSLOTS)) u_mask (
        .en_i   (st_q.busy),
        .slot_i (st_q.slot),
        .mask_o (slot_mask)
    );

    fis_hdr_build #(.KIND(KIND_PIO_SETUP)) u_pio_hdr (
        .irq_flag_i (irq_flag),
        .status_i   (dev_status_i),
        .error_i    (dev_error_i),
        .hdr_o      (pio_hdr)
    );

    fis_hdr_build #(.KIND(KIND_REG_D2H)) u_d2h_hdr (
        .irq_flag_i (1'b1),
        .status_i   (dev_status_i),
        .error_i    (dev_error_i),
        .hdr_o      (d2h_hdr)
    );

    assign done_ok = done_i && st_q.busy;
    assign pio_ok  = pio_end_i && st_q.busy && !done_i;

    always_comb begin
        st_d         = st_q;
        st_d.pio_we  = 1'b0;
        st_d.d2h_we  = 1'b0;
        st_d.pss     = 1'b0;
        st_d.tfes    = 1'b0;
        st_d.dhrs    = 1'b0;
        st_d.copy    = 1'b0;
        st_d.clr     = '0;
        st_d.recheck = 1'b0;

        if (done_ok) begin
            st_d.clr     = slot_mask;
            st_d.recheck = |(issue_i & ~slot_mask);
            st_d.d2h_we  = 1'b1;
            st_d.d2h     = d2h_hdr;
            st_d.dhrs    = 1'b1;
            st_d.busy    = 1'b0;
        end else if (pio_ok) begin
            st_d.pio_we    = 1'b1;
            st_d.pio       = pio_hdr;
            st_d.pss       = irq_flag;
            st_d.tfes      = err_seen;
            st_d.copy      = copy_ok;
            st_d.first_drq = 1'b1;
        end

        if (!done_ok && rx_on_i && !st_q.init_sent) begin
            st_d.d2h_we    = 1'b1;
            st_d.d2h       = d2h_hdr;
            st_d.dhrs      = 1'b1;
            st_d.init_sent = 1'b1;
        end

        if (start_i && !st_q.busy) begin
            st_d.busy      = 1'b1;
            st_d.slot      = start_slot_i;
            st_d.atapi     = start_atapi_i;
            st_d.write     = start_write_i;
            st_d.first_drq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pio_fis_we_o = st_q.pio_we;
    assign pio_fis_o    = st_q.pio;
    assign d2h_fis_we_o = st_q.d2h_we;
    assign d2h_fis_o    = st_q.d2h;
    assign irq_pss_o    = st_q.pss;
    assign irq_tfes_o   = st_q.tfes;
    assign irq_dhrs_o   = st_q.dhrs;
    assign copy_en_o    = st_q.copy;
    assign ci_clr_o     = st_q.clr;
    assign recheck_o    = st_q.recheck;
    assign busy_valid_o = st_q.busy;
    assign busy_slot_o  = st_q.slot;

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_valid_o) |=> (busy_valid_o && busy_slot_o == $past(start_slot_i)));

    // R5
    pss_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pss_o |-> (pio_fis_we_o && pio_fis_o[8 + IRQ_FLAG_BIT]));

    // R7
    copy_with_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en_o |-> pio_fis_we_o);

    // R8
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ci_clr_o));

    // R8
    clr_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ci_clr_o != '0) |-> (d2h_fis_we_o && irq_dhrs_o && !busy_valid_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_valid_o) |=> (!pio_fis_we_o && ci_clr_o == '0));
endmodule

// File: tb/pio_fis_seq_tb.sv
module pio_fis_seq_tb_top;
    localparam int NS = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 0, start_atapi_i = 0, start_write_i = 0;
    logic [SW-1:0] start_slot_i = '0;
    logic [NS-1:0] issue_i = '0;
    logic [7:0]    dev_status_i = '0, dev_error_i = '0;
    logic          pio_end_i = 0, done_i = 0, rx_on_i = 0;

    logic          pio_fis_we_o, d2h_fis_we_o, irq_pss_o, irq_tfes_o, irq_dhrs_o;
    logic          copy_en_o, recheck_o, busy_valid_o;
    logic [31:0]   pio_fis_o, d2h_fis_o;
    logic [NS-1:0] ci_clr_o;
    logic [SW-1:0] busy_slot_o;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    pio_fis_seq #(.NSLOTS(NS)) dut_i (.*);

    // behavioural reference
    bit       m_busy, m_atapi, m_wr, m_fd, m_init;
    int       m_slot;
    bit       e_pwe, e_dwe, e_pss, e_tfes, e_dhrs, e_copy, e_rchk;
    bit [31:0] e_pio, e_d2h;
    bit [NS-1:0] e_clr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_atapi = 0; m_wr = 0; m_fd = 0; m_init = 0; m_slot = 0;
            e_pwe = 0; e_dwe = 0; e_pss = 0; e_tfes = 0; e_dhrs = 0; e_copy = 0; e_rchk = 0;
            e_pio = 0; e_d2h = 0; e_clr = 0;
        end else begin
            bit was_busy, did_done, flag;
            was_busy = m_busy;
            did_done = 0;
            e_pwe = 0; e_dwe = 0; e_pss = 0; e_tfes = 0; e_dhrs = 0; e_copy = 0; e_rchk = 0;
            e_clr = 0;
            if (done_i && was_busy) begin
                did_done = 1;
                e_clr = NS'(1) << m_slot;
                e_rchk = (issue_i & ~e_clr) != 0;
                e_dwe = 1; e_dhrs = 1;
                e_d2h = {dev_error_i, dev_status_i, 8'h40, 8'h34};
                m_busy = 0;
            end else if (pio_end_i && was_busy) begin
                flag = m_fd || (!m_atapi && !m_wr);
                e_pwe = 1;
                e_pio = {dev_error_i, dev_status_i, flag ? 8'h40 : 8'h00, 8'h5F};
                e_pss = flag;
                e_tfes = dev_status_i[0];
                e_copy = !(m_atapi && !m_fd);
                m_fd = 1;
            end
            if (!did_done && rx_on_i && !m_init) begin
                e_dwe = 1; e_dhrs = 1; m_init = 1;
                e_d2h = {dev_error_i, dev_status_i, 8'h40, 8'h34};
            end
            if (start_i && !was_busy) begin
                m_busy = 1; m_slot = int'(start_slot_i);
                m_atapi = start_atapi_i; m_wr = start_write_i; m_fd = 0;
            end
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3", "pio_we", pio_fis_we_o, e_pwe);
        if (e_pwe) chk("R3/R4", "pio_fis", pio_fis_o, e_pio);
        chk("R5", "pss", irq_pss_o, e_pss);
        chk("R6", "tfes", irq_tfes_o, e_tfes);
        chk("R7", "copy", copy_en_o, e_copy);
        chk("R8", "d2h_we", d2h_fis_we_o, e_dwe);
        if (e_dwe) chk("R8", "d2h_fis", d2h_fis_o, e_d2h);
        chk("R8", "dhrs", irq_dhrs_o, e_dhrs);
        chk("R8", "ci_clr", ci_clr_o, e_clr);
        chk("R9", "recheck", recheck_o, e_rchk);
        chk("R2", "busy_valid", busy_valid_o, m_busy);
        if (m_busy) chk("R2", "busy_slot", busy_slot_o, m_slot);
    endtask

    task automatic idle_inputs();
        start_i = 0; pio_end_i = 0; done_i = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic do_start(int slot, bit atapi, bit wr);
        start_i = 1; start_slot_i = SW'(slot); start_atapi_i = atapi; start_write_i = wr;
        tick();
    endtask

    task automatic do_pio(logic [7:0] st, logic [7:0] er);
        pio_end_i = 1; dev_status_i = st; dev_error_i = er;
        tick();
    endtask

    task automatic do_done(logic [NS-1:0] iss, logic [7:0] st);
        done_i = 1; issue_i = iss; dev_status_i = st; dev_error_i = 8'h00;
        tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: outputs quiet during and right after reset
        repeat (2) @(negedge clk);
        chk("R1", "busy in reset", busy_valid_o, 0);
        chk("R1", "we in reset", pio_fis_we_o | d2h_fis_we_o, 0);
        rst_n = 1;
        tick();
        chk("R1", "clr after reset", ci_clr_o, 0);

        // R11: unsolicited record once
        rx_on_i = 1; dev_status_i = 8'h50; tick();
        chk("R11", "init d2h", d2h_fis_we_o, 1);
        tick();
        chk("R11", "no repeat", d2h_fis_we_o, 0);

        // R4/R5/R7: ATA read, first flag set
        do_start(2, 0, 0);
        do_pio(8'h58, 8'h00);
        chk("R4", "read first flag", pio_fis_o[14], 1);
        do_pio(8'h58, 8'h00);
        do_done(8'b0000_0100, 8'h50);
        chk("R9", "no pending", recheck_o, 0);

        // R4: ATA write, first flag clear, then set
        do_start(5, 0, 1);
        do_pio(8'h58, 8'h00);
        chk("R4", "write first flag", pio_fis_o[14], 0);
        do_pio(8'h58, 8'h00);
        chk("R4", "write second flag", pio_fis_o[14], 1);
        do_done(8'b0010_0100, 8'h50);
        chk("R9", "pending other", recheck_o, 1);

        // R7/R6: ATAPI, first phase no copy, error status
        do_start(7, 1, 0);
        do_pio(8'h58, 8'h00);
        chk("R7", "atapi first copy", copy_en_o, 0);
        do_pio(8'h51, 8'h04);
        chk("R6", "tfes", irq_tfes_o, 1);
        // R2: start while busy ignored
        do_start(3, 0, 0);
        chk("R2", "slot kept", busy_slot_o, 7);
        do_done(8'b1000_0000, 8'h50);
        chk("R8", "clr slot7", ci_clr_o, 8'h80);

        // R10: idle events ignored; done wins over pio
        do_pio(8'h58, 8'h00);
        do_done(8'h00, 8'h50);
        chk("R10", "idle done", ci_clr_o, 0);
        do_start(1, 0, 0);
        pio_end_i = 1; done_i = 1; tick();
        chk("R10", "done wins", pio_fis_we_o, 0);

        // R11: deferred behind completion
        rst_n = 0; rx_on_i = 0; @(negedge clk); rst_n = 1; tick();
        do_start(1, 0, 0);
        rx_on_i = 1; done_i = 1; issue_i = '0; tick();
        chk("R11", "completion first", ci_clr_o, 8'h02);
        tick();
        chk("R11", "deferred init", d2h_fis_we_o, 1);

        // random phase
        for (int i = 0; i < 600; i++) begin
            start_i = ($urandom % 4) == 0; start_slot_i = SW'($urandom);
            start_atapi_i = $urandom; start_write_i = $urandom;
            pio_end_i = ($urandom % 3) == 0; done_i = ($urandom % 6) == 0;
            issue_i = NS'($urandom); dev_status_i = 8'($urandom); dev_error_i = 8'($urandom);
            rx_on_i = $urandom;
            @(negedge clk);
            compare_all();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule